// File: doc/BRIEF.md
# Serial Peripheral Slave Port with Select Resynchronization

This block is the target side of a four-wire serial link. The remote controller drives the serial clock, the select line and the inbound data, and the block exchanges one 8-bit byte per frame in both directions, most significant bit first. All three serial inputs pass through two-flop synchronizers into the system clock domain. Every serial clock transition is found by comparing the synchronized clock with its value one cycle earlier.

Local logic loads the outbound byte through a parallel write port. The received byte appears in a buffer register once the eighth bit has been sampled, and a sticky completion flag is raised at the same time. A polarity input sets the idle level of the serial clock. An edge-select input chooses whether inbound data is sampled on the leading edge or on the trailing edge of each clock pulse. A 4-bit mode field chooses between select-gated operation and always-selected operation. Raising select at any point ends the frame at once. It releases the output, clears the bit counter and throws away the partial byte.

Top module: `spi_slave_sync`

## Requirements
- R1: After reset, sdo_oe_o, done_flag_o, wcol_o and ovf_o are 0 and rdata_o is 8'h00.
- R2: Inbound bits are shifted in MSB first. After the eighth sample edge of a frame, the byte appears on rdata_o and done_flag_o is set.
- R3: Outbound bits leave MSB first from the byte last written. With cke_i=0, bit 7 is on sdo_o before the first clock edge, and each later bit changes on a trailing edge. With cke_i=1, each bit is driven on a leading edge. In both settings the bit is stable at the sample edge.
- R4: The leading edge is the transition away from the idle level set by ckp_i (idle low when ckp_i=0, idle high when ckp_i=1), and the trailing edge is the return to that level. Both polarities transfer data correctly.
- R5: sdo_oe_o is 1 exactly when en_i=1, the configuration is legal, and either mode_i=4'b0100 with the synchronized select low, or mode_i=4'b0101.
- R6: In mode 4'b0100, a rise of select partway through a byte drops sdo_oe_o two clocks later. It leaves done_flag_o clear and rdata_o unchanged, and the next frame starts again from bit 7.
- R7: Clearing en_i partway through a byte resets the bit counter, so the next frame receives a complete, correctly aligned byte.
- R8: mode_i=4'b0101 with cke_i=0 transfers data with select ignored. mode_i=4'b0101 with cke_i=1 is illegal: no output drive and no completion.
- R9: A write while a byte is in progress sets wcol_o and does not alter the byte being sent.
- R10: A byte that completes while the previous byte is still unread sets ovf_o and done_flag_o and leaves rdata_o holding the older byte.
- R11: flag_clr_i clears done_flag_o, wcol_o and ovf_o. A new event in the same cycle takes precedence over the clear. rd_i marks the buffer as read, so the next completion does not overflow.
- R12: mode_i values other than 4'b0100 and 4'b0101 leave the port inactive: no drive and no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the remote controller |
| sdi_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Active-low select |
| en_i | input | 1 | Port enable |
| mode_i | input | 4 | Operating mode: 4'b0100 select-gated, 4'b0101 always selected |
| ckp_i | input | 1 | Serial clock idle level |
| cke_i | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| wr_i | input | 1 | Write strobe for the outbound byte |
| wdata_i | input | 8 | Outbound byte |
| rd_i | input | 1 | Read strobe, marks the buffer as read |
| flag_clr_i | input | 1 | Clears the sticky flags |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o; 0 means high impedance |
| rdata_o | output | 8 | Last received byte |
| done_flag_o | output | 1 | Sticky byte-complete flag |
| wcol_o | output | 1 | Sticky write-collision flag |
| ovf_o | output | 1 | Sticky receive-overflow flag |

## Verification
The assertions assume that the remote controller holds each serial clock phase, and the data setup before a sample edge, for several system clocks. They also assume that mode, polarity and edge settings change only while en_i is low and the clock rests at its idle level. The stimulus meets these assumptions by holding each phase for eight clocks and setting inbound data six clocks before its sample edge. It reconfigures only with the port disabled, and it only raises select with the clock idle.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

    localparam logic [3:0] MODE_SEL_GATED = 4'b0100;
    localparam logic [3:0] MODE_ALWAYS_ON = 4'b0101;

    typedef struct packed {
        logic lead;
        logic trail;
    } sck_edge_t;

    typedef struct packed {
        logic ovf;
        logic wcol;
        logic done;
    } flags_t;

    function automatic logic cfg_legal(input logic [3:0] mode, input logic cke);
        return (mode == MODE_SEL_GATED) || ((mode == MODE_ALWAYS_ON) && !cke);
    endfunction

    function automatic sck_edge_t classify_edge(input logic now, input logic prev,
                                                input logic idle_hi);
        sck_edge_t e;
        logic rise, fall;
        rise = now & ~prev;
        fall = ~now & prev;
        e.lead  = idle_hi ? fall : rise;
        e.trail = idle_hi ? rise : fall;
        return e;
    endfunction

endpackage

// File: rtl/spi_sync_in.sv
module spi_sync_in #(
    parameter int unsigned    W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta, stab;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta <= RST_VAL[i];
                stab <= RST_VAL[i];
            end else begin
                meta <= d[i];
                stab <= meta;
            end
        end
        assign q[i] = stab;
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_slave_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          ckp,
    input  logic          cke,
    input  logic          sck_s,
    input  logic          sdi_s,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          sdo_bit,
    output logic          done,
    output logic [DW-1:0] rx_byte,
    output logic          wcol_evt
);
    localparam int unsigned CW = $clog2(DW);

    logic          sck_d;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sr;
    sck_edge_t     edg;
    logic          sample, drive, last;

    assign edg    = classify_edge(sck_s, sck_d, ckp);
    assign sample = run & (cke ? edg.trail : edg.lead);
    assign drive  = run & (cke ? edg.lead : edg.trail);
    assign last   = (cnt == CW'(DW - 1));

    assign wcol_evt = wr & ((cnt != '0) | sample);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d   <= 1'b0;
            cnt     <= '0;
            sr      <= '0;
            sdo_bit <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            sck_d <= sck_s;
            done  <= sample & last;
            if (sample & last)
                rx_byte <= {sr[DW-2:0], sdi_s};
            if (!run)
                cnt <= '0;
            else if (sample) begin
                sr  <= {sr[DW-2:0], sdi_s};
                cnt <= last ? '0 : cnt + 1'b1;
            end
            if (drive)
                sdo_bit <= sr[DW-1];
            if (wr && !wcol_evt) begin
                sr      <= wdata;
                sdo_bit <= wdata[DW-1];
            end
        end
    end
endmodule

// File: rtl/spi_rx_buffer.sv
module spi_rx_buffer
    import spi_slave_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          done,
    input  logic [DW-1:0] rx_byte,
    input  logic          wcol_evt,
    input  logic          rd,
    input  logic          clr,
    output logic [DW-1:0] rdata,
    output flags_t        flags
);
    logic unread;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            unread <= 1'b0;
            flags  <= '0;
        end else begin
            flags.done <= (flags.done & ~clr) | done;
            flags.wcol <= (flags.wcol & ~clr) | wcol_evt;
            flags.ovf  <= (flags.ovf  & ~clr) | (done & unread);
            if (done) begin
                if (!unread) begin
                    rdata  <= rx_byte;
                    unread <= 1'b1;
                end
            end else if (rd) begin
                unread <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync
    import spi_slave_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              ss_n_i,
    input  logic              en_i,
    input  logic [3:0]        mode_i,
    input  logic              ckp_i,
    input  logic              cke_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    input  logic              flag_clr_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_flag_o,
    output logic              wcol_o,
    output logic              ovf_o
);
    logic [2:0]        pins_s;
    logic              sck_s, sdi_s, ss_n_s;
    logic              active, selected;
    logic              done_pulse, wcol_evt;
    logic [DATA_W-1:0] rx_byte;
    flags_t            flags;

    spi_sync_in #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ss_n_i, sdi_i, sck_i}),
        .q   (pins_s)
    );
    assign {ss_n_s, sdi_s, sck_s} = pins_s;

    assign active   = en_i & cfg_legal(mode_i, cke_i);
    assign selected = (mode_i == MODE_ALWAYS_ON) | ~ss_n_s;
    assign sdo_oe_o = active & selected;

    spi_shift_core #(.DW(DATA_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .run      (sdo_oe_o),
        .ckp      (ckp_i),
        .cke      (cke_i),
        .sck_s    (sck_s),
        .sdi_s    (sdi_s),
        .wr       (wr_i),
        .wdata    (wdata_i),
        .sdo_bit  (sdo_o),
        .done     (done_pulse),
        .rx_byte  (rx_byte),
        .wcol_evt (wcol_evt)
    );

    spi_rx_buffer #(.DW(DATA_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .done     (done_pulse),
        .rx_byte  (rx_byte),
        .wcol_evt (wcol_evt),
        .rd       (rd_i),
        .clr      (flag_clr_i),
        .rdata    (rdata_o),
        .flags    (flags)
    );

    assign done_flag_o = flags.done;
    assign wcol_o      = flags.wcol;
    assign ovf_o       = flags.ovf;
endmodule

// File: rtl/spi_slave_sync_chk.sv
module spi_slave_sync_chk (
    input logic       clk,
    input logic       rst,
    input logic       en_i,
    input logic [3:0] mode_i,
    input logic       cke_i,
    input logic       wr_i,
    input logic       sdo_oe_o,
    input logic       done_flag_o,
    input logic       wcol_o,
    input logic       ovf_o
);
    // R5
    oe_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        sdo_oe_o |-> en_i);

    // R8
    illegal_cfg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 4'b0101 && cke_i) |-> !sdo_oe_o);

    // R12
    bad_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i != 4'b0100 && mode_i != 4'b0101) |-> !sdo_oe_o);

    // R9
    wcol_from_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wcol_o) |-> $past(wr_i));

    // R10
    ovf_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> done_flag_o);
endmodule

bind spi_slave_sync spi_slave_sync_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .mode_i      (mode_i),
    .cke_i       (cke_i),
    .wr_i        (wr_i),
    .sdo_oe_o    (sdo_oe_o),
    .done_flag_o (done_flag_o),
    .wcol_o      (wcol_o),
    .ovf_o       (ovf_o)
);

// File: tb/spi_slave_sync_bench.sv
`timescale 1ns/1ps
module spi_slave_sync_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0, sdi = 1'b0, ss_n = 1'b1, en = 1'b0;
    logic [3:0] mode = 4'b0100;
    logic       ckp = 1'b0, cke = 1'b0, wr = 1'b0, rd = 1'b0, clr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       sdo, sdo_oe, done_flag, wcol, ovf;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic ss_q1 = 1'b1, ss_q2 = 1'b1;

    always #2 clk = ~clk;

    spi_slave_sync u_spi_slave_sync (
        .clk (clk), .rst (rst), .sck_i (sck), .sdi_i (sdi), .ss_n_i (ss_n),
        .en_i (en), .mode_i (mode), .ckp_i (ckp), .cke_i (cke),
        .wr_i (wr), .wdata_i (wdata), .rd_i (rd), .flag_clr_i (clr),
        .sdo_o (sdo), .sdo_oe_o (sdo_oe), .rdata_o (rdata),
        .done_flag_o (done_flag), .wcol_o (wcol), .ovf_o (ovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // select seen by the port two clocks after the pin
    always @(posedge clk) begin
        if (rst) begin
            ss_q1 <= 1'b1;
            ss_q2 <= 1'b1;
        end else begin
            ss_q1 <= ss_n;
            ss_q2 <= ss_q1;
        end
    end

    // R5: output enable reference compared on every clock
    always @(negedge clk) begin
        if (!rst) begin
            bit legal, exp_oe;
            legal  = (mode == 4'b0100) || (mode == 4'b0101 && !cke);
            exp_oe = en && legal && (mode == 4'b0101 || !ss_q2);
            chk("R5 sdo_oe", {31'd0, sdo_oe}, {31'd0, exp_oe});
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic cfg(input logic p, input logic e, input logic [3:0] m);
        en = 1'b0;
        tick(1);
        ckp = p; sck = p; cke = e; mode = m;
        tick(6);
        en = 1'b1;
        tick(2);
    endtask

    task automatic wbyte(input logic [7:0] d);
        wr = 1'b1; wdata = d;
        tick(1);
        wr = 1'b0;
        tick(1);
    endtask

    task automatic rbyte();
        rd = 1'b1; tick(1); rd = 1'b0; tick(1);
    endtask

    task automatic clear();
        clr = 1'b1; tick(1); clr = 1'b0; tick(1);
    endtask

    task automatic xfer(input logic [7:0] mosi, output logic [7:0] miso,
                        input int nbits, input bit use_ss,
                        input bit wr_mid, input logic [7:0] mid);
        miso = 8'h00;
        if (use_ss) ss_n = 1'b0;
        tick(6);
        for (int i = 0; i < nbits; i++) begin
            if (!cke) begin
                sdi = mosi[7-i];
                tick(6);
                miso[7-i] = sdo;
                sck = ~ckp;
                tick(8);
                if (wr_mid && i == 3) begin
                    wr = 1'b1; wdata = mid; tick(1); wr = 1'b0;
                end
                sck = ckp;
                tick(8);
            end else begin
                sck = ~ckp;
                tick(6);
                sdi = mosi[7-i];
                miso[7-i] = sdo;
                tick(6);
                if (wr_mid && i == 3) begin
                    wr = 1'b1; wdata = mid; tick(1); wr = 1'b0;
                end
                sck = ckp;
                tick(8);
            end
        end
        tick(6);
    endtask

    task automatic deselect();
        ss_n = 1'b1;
        tick(6);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] got, tx, rxv, last_rx;
        tick(4);
        rst = 1'b0;
        tick(2);
        // R1
        chk("R1 oe", {31'd0, sdo_oe}, 0);
        chk("R1 flag", {31'd0, done_flag}, 0);
        chk("R1 wcol", {31'd0, wcol}, 0);
        chk("R1 ovf", {31'd0, ovf}, 0);
        chk("R1 rdata", {24'd0, rdata}, 0);

        // R2 R3 R4: all four clock settings
        for (int k = 0; k < 4; k++) begin
            tx  = 8'hA5 ^ (8'(k) * 8'h3C);
            rxv = 8'h5A + 8'(k) * 8'd37;
            cfg(k[1], k[0], 4'b0100);
            wbyte(tx);
            xfer(rxv, got, 8, 1, 0, 8'h00);
            chk(k[1] ? "R3 R4 tx byte" : "R3 tx byte", {24'd0, got}, {24'd0, tx});
            chk("R2 done flag", {31'd0, done_flag}, 1);
            chk(k[1] ? "R2 R4 rx byte" : "R2 rx byte", {24'd0, rdata}, {24'd0, rxv});
            deselect();
            rbyte();
            clear();
            chk("R11 flag cleared", {31'd0, done_flag}, 0);
            last_rx = rxv;
        end

        // R6: abort by select mid-byte
        cfg(0, 0, 4'b0100);
        wbyte(8'hC3);
        xfer(8'hFF, got, 3, 1, 0, 8'h00);
        ss_n = 1'b1;
        tick(3);
        chk("R6 oe released", {31'd0, sdo_oe}, 0);
        tick(6);
        chk("R6 no flag", {31'd0, done_flag}, 0);
        chk("R6 buffer kept", {24'd0, rdata}, {24'd0, last_rx});
        wbyte(8'h3C);
        xfer(8'h96, got, 8, 1, 0, 8'h00);
        chk("R6 realigned rx", {24'd0, rdata}, 8'h96);
        chk("R6 realigned tx", {24'd0, got}, 8'h3C);
        deselect(); rbyte(); clear();

        // R7: disable mid-byte
        cfg(1, 0, 4'b0100);
        wbyte(8'hF0);
        xfer(8'h00, got, 5, 1, 0, 8'h00);
        en = 1'b0; tick(4); en = 1'b1; tick(2);
        chk("R7 no flag", {31'd0, done_flag}, 0);
        wbyte(8'h0F);
        xfer(8'hB2, got, 8, 0, 0, 8'h00);
        chk("R7 rx aligned", {24'd0, rdata}, 8'hB2);
        chk("R7 tx aligned", {24'd0, got}, 8'h0F);
        deselect(); rbyte(); clear();

        // R9: write collision
        cfg(0, 1, 4'b0100);
        wbyte(8'h81);
        xfer(8'h11, got, 8, 1, 1, 8'hFF);
        chk("R9 wcol set", {31'd0, wcol}, 1);
        chk("R9 tx unchanged", {24'd0, got}, 8'h81);
        deselect(); rbyte(); clear();
        chk("R11 wcol cleared", {31'd0, wcol}, 0);

        // R10: overflow
        cfg(0, 0, 4'b0100);
        xfer(8'h22, got, 8, 1, 0, 8'h00);
        deselect();
        xfer(8'h44, got, 8, 1, 0, 8'h00);
        deselect();
        chk("R10 ovf set", {31'd0, ovf}, 1);
        chk("R10 buffer kept", {24'd0, rdata}, 8'h22);
        clear();
        chk("R11 ovf cleared", {31'd0, ovf}, 0);
        rbyte();
        xfer(8'h66, got, 8, 1, 0, 8'h00);
        deselect();
        chk("R11 read then no ovf", {31'd0, ovf}, 0);
        chk("R11 new byte", {24'd0, rdata}, 8'h66);
        rbyte(); clear();

        // R8: always-selected mode
        cfg(0, 0, 4'b0101);
        wbyte(8'h6E);
        xfer(8'h19, got, 8, 0, 0, 8'h00);
        chk("R8 no-select tx", {24'd0, got}, 8'h6E);
        chk("R8 no-select rx", {24'd0, rdata}, 8'h19);
        rbyte(); clear();

        // R8: illegal combination
        cfg(1, 1, 4'b0101);
        xfer(8'h77, got, 8, 0, 0, 8'h00);
        chk("R8 illegal no flag", {31'd0, done_flag}, 0);
        chk("R8 illegal no drive", {31'd0, sdo_oe}, 0);
        chk("R8 illegal buffer", {24'd0, rdata}, 8'h19);

        // R12: unsupported mode
        cfg(0, 0, 4'b0000);
        xfer(8'h55, got, 8, 1, 0, 8'h00);
        chk("R12 no drive", {31'd0, sdo_oe}, 0);
        chk("R12 no flag", {31'd0, done_flag}, 0);
        deselect();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule